// File: doc/BRIEF.md
# SMBus Register Target with Broadcast and Alert Response

This block is the bus-side target of a device holding four byte-wide control registers. It oversamples the two-wire clock and data lines with the system clock. From the samples it recognises START, repeated START and STOP, and it decodes the 7-bit address. It accepts Write Byte and Read Byte transfers, and it answers the alert response read. The register file sits outside the block. The block issues a one-cycle write strobe carrying an index and a data byte. It takes all register contents in on a flat read bus. Its only drive onto the bus is an open-drain pull-down request for SDA, which the pad turns into a low.

The device address has a fixed `10` prefix. The low five bits come from three address pins, each already resolved outside the block into a 2-bit code. Two other addresses are special. A broadcast write address reaches every such device, and a mass-write-enable input can mask it. The alert response address gets an answer only while an alert is pending. A write is held in a holding register and commits only on the STOP that closes a complete Write Byte. A repeated START or an extra byte throws the write away.

Top module: `smb_reg_target`

## Requirements
- R1: The own address is `{2'b10, N}`, where N = 9·p2 + 3·p1 + p0. Pin pK is the 2-bit code in `addr_code_i[2K+1:2K]`: 0, 1 or 2, with code 3 read as 2. The block ACKs its own address and leaves SDA released (NACK) for any unlisted address.
- R2: An own-address write followed by a command byte 0..3, a data byte and STOP gives exactly one `wr_stb_o` pulse. The pulse comes after the STOP, with `wr_idx_o` equal to the command and `wr_data_o` equal to the data.
- R3: A command byte of 4 or more is NACKed, and no write follows.
- R4: A repeated START after the data byte of a write discards that write: no strobe is issued, and the register keeps its old value.
- R5: A write to the broadcast address 1011101 is accepted like an own-address write while `mass_wr_en_i` is 1. It is NACKed and writes nothing while `mass_wr_en_i` is 0.
- R6: A Read Byte works as follows. The host sends the own address with write, a command byte, a repeated START, then the own address with read. The block returns register[command] MSB first and releases SDA after a host NACK. A read of the own address with no command byte earlier in the same transfer is NACKed.
- R7: While `alert_pend_i` is 1, a read of 0001100 is ACKed. The block returns `{own address, 1'b0}` and pulses `ara_done_o` once. While `alert_pend_i` is 0, that address is NACKed.
- R8: While `enable_i` is 0 or `uvlo_i` is 1, the block acknowledges nothing, holds SDA released and issues no write.
- R9: `addr_hit_o` pulses once for each ACKed own-address byte. It does not pulse for the broadcast or alert response addresses.
- R10: A third byte after the data byte of a write is NACKed, and the write is discarded.
- R11: After reset, SDA is released and no strobe or event pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Bus participation allowed when 1 |
| uvlo_i | input | 1 | Supply lockout, blocks the bus when 1 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_code_i | input | 2*PINS | Per-pin 2-bit address codes, pin 0 in the low bits |
| mass_wr_en_i | input | 1 | Broadcast write mask (1 accepts) |
| alert_pend_i | input | 1 | Alert pending, allows the alert response |
| rd_regs_i | input | REG_COUNT*8 | Contents of all registers, register 0 in the low byte |
| sda_pull_o | output | 1 | Request to pull SDA low |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_idx_o | output | IDX_W | Register index of the write |
| wr_data_o | output | 8 | Data of the write |
| addr_hit_o | output | 1 | Pulse when the own address is acknowledged |
| ara_done_o | output | 1 | Pulse when an alert response has been sent |

## Verification
The hardest case to reach is a staged write that never commits. A host has to deliver a complete, acknowledged data byte and then close the transfer with a repeated START instead of a STOP. The bench builds this from bit-level host tasks. It then reads the same register back through the repeated START, which proves the old value survived. A second hard case is the alert response. The bench raises the pending input, reads the special address, and compares the returned byte with the address computed from the pin codes.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'b1011101;
  localparam logic [ADDR_W-1:0] ARA_ADDR   = 7'b0001100;
  localparam logic [1:0]        ADDR_PFX   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_WDONE,
    ST_TX,
    ST_IGNORE
  } smbt_state_e;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/smbt_addr_decode.sv
module smbt_addr_decode
  import smbt_pkg::*;
#(
  parameter int PINS = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [2*PINS-1:0]   code_i,
  output logic [ADDR_W-1:0]   own_addr_o
);
  localparam int LOW_W = ADDR_W - 2;

  logic [1:0] pin_val [PINS];
  logic [7:0] acc;

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign pin_val[i] = (code_i[2*i+1:2*i] == 2'd3) ? 2'd2 : code_i[2*i+1:2*i];
    end
  endgenerate

  always_comb begin
    acc = 8'd0;
    for (int i = PINS - 1; i >= 0; i--) begin
      acc = acc * 8'd3 + {6'd0, pin_val[i]};
    end
  end

  always_ff @(posedge clk_i) begin
    own_addr_o <= {ADDR_PFX, acc[LOW_W-1:0]};
  end

  p_addr_stable_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $stable(code_i) |=> $stable(own_addr_o));
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smbt_pkg::*;
#(
  parameter int REG_COUNT   = 4,
  parameter int PINS        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        enable_i,
  input  logic                        uvlo_i,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic [2*PINS-1:0]           addr_code_i,
  input  logic                        mass_wr_en_i,
  input  logic                        alert_pend_i,
  input  logic [REG_COUNT*BYTE_W-1:0] rd_regs_i,
  output logic                        sda_pull_o,
  output logic                        wr_stb_o,
  output logic [IDX_W-1:0]            wr_idx_o,
  output logic [BYTE_W-1:0]           wr_data_o,
  output logic                        addr_hit_o,
  output logic                        ara_done_o
);
  localparam logic [BYTE_W-1:0] REG_LIM  = BYTE_W'(REG_COUNT);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(REG_COUNT - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smbt_addr_decode #(.PINS(PINS)) u_addr (
    .clk_i(clk_i), .rst_i(rst_i), .code_i(addr_code_i), .own_addr_o(own_addr)
  );

  smbt_state_e st, follow_st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  cmd_idx, stage_idx;
  logic [BYTE_W-1:0] stage_data;
  logic              cmd_ok, staged, tx_ara, host_ack;
  logic              active;

  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rd;
  logic [BYTE_W-1:0] cur_rd, next_rd;
  logic [IDX_W-1:0]  next_idx;

  assign active   = enable_i & ~uvlo_i;
  assign rx_addr  = shreg[BYTE_W-1:1];
  assign rx_rd    = shreg[0];
  assign next_idx = (cmd_idx == LAST_IDX) ? '0 : cmd_idx + 1'b1;
  assign cur_rd   = rd_regs_i[cmd_idx*BYTE_W +: BYTE_W];
  assign next_rd  = rd_regs_i[next_idx*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i) begin
    if (rst_i || !active) begin
      st         <= ST_IDLE;
      follow_st  <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      cmd_idx    <= '0;
      cmd_ok     <= 1'b0;
      staged     <= 1'b0;
      tx_ara     <= 1'b0;
      host_ack   <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_stb_o   <= 1'b0;
      addr_hit_o <= 1'b0;
      ara_done_o <= 1'b0;
    end else begin
      wr_stb_o   <= 1'b0;
      addr_hit_o <= 1'b0;
      ara_done_o <= 1'b0;
      if (start_det) begin
        // a repeated START drops any staged write; the command survives
        st         <= ST_ADDR;
        bit_cnt    <= '0;
        staged     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        if (staged && st == ST_WDONE) begin
          wr_stb_o <= 1'b1;
        end
        st         <= ST_IDLE;
        staged     <= 1'b0;
        cmd_ok     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (bit_cnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
          end
          ST_WDONE: bit_cnt <= 4'd1;
          ST_TX: begin
            if (bit_cnt == 4'd8) host_ack <= ~sda_s;
            if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_ADDR: begin
            if (bit_cnt == 4'd8) begin
              if (rx_addr == own_addr && !rx_rd) begin
                sda_pull_o <= 1'b1;
                addr_hit_o <= 1'b1;
                cmd_ok     <= 1'b0;
                follow_st  <= ST_CMD;
              end else if (rx_addr == own_addr && rx_rd && cmd_ok) begin
                sda_pull_o <= 1'b1;
                addr_hit_o <= 1'b1;
                tx_ara     <= 1'b0;
                follow_st  <= ST_TX;
              end else if (rx_addr == BCAST_ADDR && !rx_rd && mass_wr_en_i) begin
                sda_pull_o <= 1'b1;
                cmd_ok     <= 1'b0;
                follow_st  <= ST_CMD;
              end else if (rx_addr == ARA_ADDR && rx_rd && alert_pend_i) begin
                sda_pull_o <= 1'b1;
                tx_ara     <= 1'b1;
                follow_st  <= ST_TX;
              end else begin
                cmd_ok <= 1'b0;
                st     <= ST_IGNORE;
              end
            end else if (bit_cnt == 4'd9) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              st         <= follow_st;
              if (follow_st == ST_TX) begin
                shreg      <= tx_ara ? {own_addr, 1'b0} : cur_rd;
                sda_pull_o <= tx_ara ? ~own_addr[ADDR_W-1] : ~cur_rd[BYTE_W-1];
              end
            end
          end
          ST_CMD: begin
            if (bit_cnt == 4'd8) begin
              if (shreg < REG_LIM) begin
                sda_pull_o <= 1'b1;
                cmd_idx    <= shreg[IDX_W-1:0];
                cmd_ok     <= 1'b1;
              end else begin
                st <= ST_IGNORE;
              end
            end else if (bit_cnt == 4'd9) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              st         <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (bit_cnt == 4'd8) begin
              sda_pull_o <= 1'b1;
              stage_idx  <= cmd_idx;
              stage_data <= shreg;
              staged     <= 1'b1;
            end else if (bit_cnt == 4'd9) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              st         <= ST_WDONE;
            end
          end
          ST_WDONE: begin
            // a full clock after the data byte means an extra byte
            if (bit_cnt != 4'd0) begin
              staged <= 1'b0;
              st     <= ST_IGNORE;
            end
          end
          ST_TX: begin
            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
              sda_pull_o <= ~shreg[BYTE_W-2];
              shreg      <= {shreg[BYTE_W-2:0], 1'b0};
            end else if (bit_cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
            end else if (bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              if (tx_ara) begin
                ara_done_o <= 1'b1;
                st         <= ST_IGNORE;
              end else if (host_ack) begin
                cmd_idx    <= next_idx;
                shreg      <= next_rd;
                sda_pull_o <= ~next_rd[BYTE_W-1];
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (stop_det && staged && st == ST_WDONE) begin
      wr_idx_o  <= stage_idx;
      wr_data_o <= stage_data;
    end
  end

  p_stb_after_stop_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_stb_o |-> $past(stop_det));
  p_quiet_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !active |=> (!sda_pull_o && !wr_stb_o && !addr_hit_o));
  p_hit_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    addr_hit_o |=> !addr_hit_o);
  p_ara_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ara_done_o |=> !ara_done_o);
  p_pull_on_fall_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sda_pull_o) |-> $past(scl_fall));
endmodule

// File: tb/test_smb_reg_target.sv
module test_smb_reg_target;
  localparam int Q  = 8;
  localparam int NV = 8;

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] cmd;
    logic [7:0] data;
    logic       mwe;
    logic       exp_ack;
    logic       exp_wr;
  } vec_t;

  localparam logic [6:0] OWN = 7'h4F;
  localparam vec_t [0:NV-1] VECS = '{
    '{OWN,   8'd0, 8'hA5, 1'b0, 1'b1, 1'b1},
    '{OWN,   8'd3, 8'h3C, 1'b0, 1'b1, 1'b1},
    '{7'h5D, 8'd1, 8'h77, 1'b1, 1'b1, 1'b1},
    '{7'h5D, 8'd2, 8'h11, 1'b0, 1'b0, 1'b0},
    '{7'h4E, 8'd1, 8'h22, 1'b0, 1'b0, 1'b0},
    '{7'h5A, 8'd1, 8'h33, 1'b0, 1'b0, 1'b0},
    '{OWN,   8'd2, 8'hFF, 1'b1, 1'b1, 1'b1},
    '{7'h0C, 8'd0, 8'h44, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, enable, uvlo, scl_h, sda_h, mwe, alert;
  logic [5:0]  code;
  logic [7:0]  regm [4];
  logic [31:0] rd_regs;
  logic sda_pull, wr_stb, addr_hit, ara_done;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  logic sda_line;

  int tests = 0, fails = 0;
  int stb_cnt = 0, hit_cnt = 0, ara_cnt = 0;
  bit done = 0;

  assign sda_line = sda_h & ~sda_pull;
  assign rd_regs  = {regm[3], regm[2], regm[1], regm[0]};

  smb_reg_target i_smb_reg_target (
    .clk_i(clk), .rst_i(rst), .enable_i(enable), .uvlo_i(uvlo),
    .scl_i(scl_h), .sda_i(sda_line), .addr_code_i(code),
    .mass_wr_en_i(mwe), .alert_pend_i(alert), .rd_regs_i(rd_regs),
    .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .addr_hit_o(addr_hit), .ara_done_o(ara_done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        stb_cnt++;
        regm[wr_idx] <= wr_data;
      end
      if (addr_hit) hit_cnt++;
      if (ara_done) ara_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; waitq(Q);
    scl_h = 1'b1; waitq(Q);
    sda_h = 1'b0; waitq(Q);
    scl_h = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; waitq(Q);
    scl_h = 1'b1; waitq(Q);
    sda_h = 1'b1; waitq(2*Q);
  endtask

  task automatic wr_bit(input logic b);
    sda_h = b;    waitq(Q);
    scl_h = 1'b1; waitq(2*Q);
    scl_h = 1'b0; waitq(Q);
  endtask

  task automatic rd_bit(output logic b);
    sda_h = 1'b1; waitq(Q);
    scl_h = 1'b1; waitq(Q);
    b = sda_line; waitq(Q);
    scl_h = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      v[i] = b;
    end
    wr_bit(~host_ack);
  endtask

  // full Write Byte; returns ack of address, command, data
  task automatic write_txn(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                           output logic aa, output logic ca, output logic da);
    ca = 1'b0; da = 1'b0;
    bus_start();
    send_byte({a, 1'b0}, aa);
    if (aa) begin
      send_byte(c, ca);
      if (ca) send_byte(d, da);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic aa, ca, da, ack;
    logic [7:0] rv;
    int s0, h0;
    rst = 1'b1; enable = 1'b1; uvlo = 1'b0; scl_h = 1'b1; sda_h = 1'b1;
    mwe = 1'b0; alert = 1'b0; code = 6'b01_10_00;
    regm[0] = 8'h10; regm[1] = 8'h21; regm[2] = 8'h32; regm[3] = 8'h43;
    waitq(5);
    rst = 1'b0;
    waitq(3);
    // R11 reset state
    check(sda_pull == 1'b0 && wr_stb == 1'b0, "R11 pull/stb", {sda_pull, wr_stb}, 0);
    check(addr_hit == 1'b0 && ara_done == 1'b0, "R11 pulses", {addr_hit, ara_done}, 0);

    // R1 R2 R5 table walk
    for (int k = 0; k < NV; k++) begin
      mwe = VECS[k].mwe;
      s0 = stb_cnt;
      write_txn(VECS[k].addr, VECS[k].cmd, VECS[k].data, aa, ca, da);
      waitq(4);
      check(aa == VECS[k].exp_ack, "R1/R5 address ack", aa, VECS[k].exp_ack);
      check((stb_cnt - s0) == int'(VECS[k].exp_wr), "R2/R5 strobe count", stb_cnt - s0, VECS[k].exp_wr);
      if (VECS[k].exp_wr)
        check(regm[VECS[k].cmd[1:0]] == VECS[k].data, "R2 register data",
              regm[VECS[k].cmd[1:0]], VECS[k].data);
    end
    mwe = 1'b0;

    // R1 clamp: code 3 on every pin reads as 2 -> 26 -> 0x5A
    code = 6'b11_11_11; waitq(4);
    write_txn(7'h5A, 8'd1, 8'h6B, aa, ca, da); waitq(4);
    check(aa && regm[1] == 8'h6B, "R1 clamped address", regm[1], 8'h6B);
    code = 6'b01_10_00; waitq(4);

    // R3 command out of range
    s0 = stb_cnt;
    write_txn(OWN, 8'd4, 8'h55, aa, ca, da); waitq(4);
    check(aa && !ca, "R3 command nack", ca, 0);
    check(stb_cnt == s0, "R3 no write", stb_cnt - s0, 0);

    // R4 repeated START after data; then read back reg1 in same transfer
    s0 = stb_cnt;
    bus_start();
    send_byte({OWN, 1'b0}, aa);
    send_byte(8'd1, ca);
    send_byte(8'h99, da);
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    recv_byte(rv, 1'b0);
    bus_stop(); waitq(4);
    check(da && stb_cnt == s0, "R4 write discarded", stb_cnt - s0, 0);
    check(ack && rv == 8'h6B, "R4 old value kept", rv, 8'h6B);

    // R6 Read Byte of register 3
    bus_start();
    send_byte({OWN, 1'b0}, aa);
    send_byte(8'd3, ca);
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    recv_byte(rv, 1'b0);
    waitq(2);
    check(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
    bus_stop(); waitq(4);
    check(ack && rv == regm[3], "R6 read data", rv, regm[3]);
    // R6 read without command
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    bus_stop(); waitq(4);
    check(!ack, "R6 read without command nack", ack, 0);

    // R7 alert response
    alert = 1'b1;
    s0 = ara_cnt;
    bus_start();
    send_byte({7'h0C, 1'b1}, ack);
    if (ack) recv_byte(rv, 1'b0);
    bus_stop(); waitq(4);
    check(ack && rv == {OWN, 1'b0}, "R7 alert response byte", rv, {OWN, 1'b0});
    check(ara_cnt - s0 == 1, "R7 served pulse", ara_cnt - s0, 1);
    alert = 1'b0;
    bus_start();
    send_byte({7'h0C, 1'b1}, ack);
    bus_stop(); waitq(4);
    check(!ack, "R7 no alert nack", ack, 0);

    // R8 enable low and lockout
    s0 = stb_cnt;
    enable = 1'b0;
    write_txn(OWN, 8'd0, 8'h01, aa, ca, da); waitq(4);
    check(!aa, "R8 enable low ack", aa, 0);
    enable = 1'b1; uvlo = 1'b1;
    write_txn(OWN, 8'd0, 8'h02, aa, ca, da); waitq(4);
    check(!aa, "R8 lockout ack", aa, 0);
    uvlo = 1'b0; waitq(4);
    check(stb_cnt == s0 && regm[0] == 8'hA5, "R8 no write", regm[0], 8'hA5);

    // R9 hit pulses: own counts, broadcast does not
    h0 = hit_cnt;
    write_txn(OWN, 8'd2, 8'h5E, aa, ca, da); waitq(4);
    check(hit_cnt - h0 == 1, "R9 own hit", hit_cnt - h0, 1);
    mwe = 1'b1; h0 = hit_cnt;
    write_txn(7'h5D, 8'd2, 8'h6E, aa, ca, da); waitq(4);
    check(hit_cnt == h0 && regm[2] == 8'h6E, "R9 broadcast no hit", hit_cnt - h0, 0);
    mwe = 1'b0;

    // R10 extra byte
    s0 = stb_cnt;
    bus_start();
    send_byte({OWN, 1'b0}, aa);
    send_byte(8'd0, ca);
    send_byte(8'h12, da);
    send_byte(8'h34, ack);
    bus_stop(); waitq(4);
    check(!ack, "R10 extra byte nack", ack, 0);
    check(stb_cnt == s0 && regm[0] == 8'hA5, "R10 write discarded", regm[0], 8'hA5);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule